// File: doc/BRIEF.md
# USB OUT Endpoint Receive FIFO

This block is the receive buffer of one OUT endpoint in a USB function. The serial engine pushes received bytes into a byte memory through a write pointer that moves forward by one on each byte. At the end of a packet it raises either a good strobe or a bad strobe. A good packet is committed. A bad packet is thrown away by moving the write pointer back to where that packet began. A CPU or DMA engine then drains the bytes through a read pointer that also moves forward by itself. A small register pair provides a packet-ready flag, an auto-clear enable, a flush command, a serviced command and the maximum packet size.

The maximum packet size sets how many packets can be held. If it is no more than half the memory depth, two packets can wait back to back. Otherwise only one packet is held. A two-entry queue stores the byte count of each held packet. Releasing a packet moves the read pointer past that packet's count. A packet is released by a 0 write to the ready bit, by the auto-clear rule, or by a flush. When the `ctrlStyle` input is high, the endpoint uses the control-endpoint convention instead: the packet is released by writing 1 to a serviced bit. When no packet slot is free, the block raises a full indication so that the engine can refuse further data.

Top module: `usbOutFifo`

## Requirements
- R1: Bytes of a committed packet are returned on `rdData` in the order they were written. `rdData` shows the byte at the read pointer, and each accepted `rdEn` moves the pointer forward by one.
- R2: After reset, `pktRdy` and `rxFull` are 0. `pktRdy` rises in the cycle after a `rxGood` strobe that finds a free slot.
- R3: When the maximum packet size is at most DEPTH/2, two packets are held; otherwise one is held. `rxFull` is 1 exactly when every slot is occupied. While `rxFull` is 1, incoming bytes and `rxGood` are ignored.
- R4: Manual release: with `ctrlStyle` at 0, a write to address 0 with bit 0 at 0 releases the oldest packet. `pktRdy` stays 1 if a second packet is held.
- R5: Auto-clear (bit 7 of address 0, with `ctrlStyle` at 0): once as many bytes as the maximum packet size have been read from the oldest packet, that packet is released without a register write. `pktRdy` stays 1 if another packet is held.
- R6: A write to address 0 with bit 4 at 1 (flush) releases only the oldest packet. When two packets are held, the next read returns byte 0 of the younger packet.
- R7: With `ctrlStyle` at 1, a 0 in bit 0 of a write to address 0 has no effect, and auto-clear has no effect. A 1 in bit 6 (serviced) releases the oldest packet.
- R8: A `rxBad` strobe discards the bytes written since the last commit and leaves `pktRdy` unchanged. The next good packet reads back correctly.
- R9: `rdEn` is ignored while `pktRdy` is 0, and also once every byte of the oldest packet has been read. In both cases `rdData` keeps its value.
- R10: Reading address 0 returns auto-clear in bit 7, `pktRdy` in bit 0 and zeros elsewhere. Reading address 1 returns the maximum packet size, which resets to DEPTH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ctrlStyle | input | 1 | 1 selects the control-endpoint release convention |
| rxValid | input | 1 | Engine byte strobe |
| rxData | input | 8 | Engine byte |
| rxGood | input | 1 | Current packet received successfully |
| rxBad | input | 1 | Current packet failed; discard it |
| rxFull | output | 1 | No free packet slot |
| rdEn | input | 1 | Consume the byte at the read pointer |
| rdData | output | 8 | Byte at the read pointer |
| pktRdy | output | 1 | At least one packet is held |
| csrWrEn | input | 1 | Register write strobe |
| csrAddr | input | 1 | 0 status/control, 1 max packet size |
| csrWrData | input | 8 | Register write data |
| csrRdData | output | 8 | Register read data for `csrAddr` |

## Verification
If the length queue holds a wrong count, the damage shows after the next release: the read pointer lands off a packet boundary, and the first byte read afterwards on `rdData` is wrong. If the packet count is wrong, `pktRdy` or `rxFull` disagrees with the bench model in the cycle after the event that changed the count. A rollback that fails is seen only when the next good packet is read out, because its bytes then come back shifted. The bench therefore reads every byte it can reach, and it checks both flags after every operation.

// File: rtl/usbOutPkg.sv
package usbOutPkg;
  typedef struct packed {
    logic wrByte;
    logic commit;
    logic rollback;
    logic rdByte;
    logic pop;
  } fifoStrobe_t;
endpackage

// File: rtl/outFifoData.sv
module outFifoData
  import usbOutPkg::*;
#(
  parameter int DEPTH = 64,
  localparam int AW = $clog2(DEPTH),
  localparam int LW = AW + 1
) (
  input  logic          clk,
  input  logic          rstN,
  input  fifoStrobe_t   st,
  input  logic [7:0]    wrData,
  input  logic [LW-1:0] popLen,
  output logic [7:0]    rdData
);
  logic [7:0]    mem [DEPTH];
  logic [AW-1:0] wrPtr, wrStart, rdBase, rdOfs;

  // storage carries no reset
  always_ff @(posedge clk) begin
    if (st.wrByte) mem[wrPtr] <= wrData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr   <= '0;
      wrStart <= '0;
      rdBase  <= '0;
      rdOfs   <= '0;
    end else begin
      if (st.rollback)    wrPtr <= wrStart;
      else if (st.wrByte) wrPtr <= wrPtr + AW'(1);
      if (st.commit)      wrStart <= wrPtr;
      // a release jumps past the whole packet, whatever was read of it
      if (st.pop) begin
        rdBase <= rdBase + popLen[AW-1:0];
        rdOfs  <= '0;
      end else if (st.rdByte) begin
        rdOfs <= rdOfs + AW'(1);
      end
    end
  end

  assign rdData = mem[rdBase + rdOfs];
endmodule

// File: rtl/outFifoCtrl.sv
module outFifoCtrl
  import usbOutPkg::*;
#(
  parameter int DEPTH = 64,
  localparam int AW = $clog2(DEPTH),
  localparam int LW = AW + 1,
  localparam int SLOTS = 2
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          ctrlStyle,
  input  logic          rxValid,
  input  logic          rxGood,
  input  logic          rxBad,
  input  logic          rdEn,
  input  logic          csrWrEn,
  input  logic          csrAddr,
  input  logic [7:0]    csrWrData,
  output fifoStrobe_t   st,
  output logic [LW-1:0] popLen,
  output logic [LW-1:0] maxPkt,
  output logic          pktRdy,
  output logic          rxFull,
  output logic [7:0]    csrRdData
);
  logic [LW-1:0] maxPktQ, curLen, rdCnt;
  logic [LW-1:0] lenQ [SLOTS];
  logic [1:0]    pktCnt, capCnt;
  logic          autoClrQ, statWr, manualClr, servClr, flushReq, autoPop;

  assign capCnt = (maxPktQ <= LW'(DEPTH / 2)) ? 2'd2 : 2'd1;
  assign rxFull = pktCnt >= capCnt;
  assign pktRdy = pktCnt != 2'd0;
  assign maxPkt = maxPktQ;
  assign popLen = lenQ[0];

  assign statWr    = csrWrEn && !csrAddr;
  assign manualClr = statWr && !ctrlStyle && !csrWrData[0];
  assign servClr   = statWr && ctrlStyle && csrWrData[6];
  assign flushReq  = statWr && csrWrData[4];

  always_comb begin
    st          = '0;
    st.rollback = rxBad;
    st.commit   = rxGood && !rxBad && !rxFull;
    st.wrByte   = rxValid && !rxGood && !rxBad && !rxFull && (curLen < maxPktQ);
    st.rdByte   = rdEn && pktRdy && (rdCnt < lenQ[0]);
    autoPop     = st.rdByte && autoClrQ && !ctrlStyle && ((rdCnt + LW'(1)) == maxPktQ);
    st.pop      = pktRdy && (manualClr || servClr || flushReq || autoPop);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      maxPktQ  <= LW'(DEPTH);
      autoClrQ <= 1'b0;
      curLen   <= '0;
      rdCnt    <= '0;
      pktCnt   <= '0;
      for (int i = 0; i < SLOTS; i++) lenQ[i] <= '0;
    end else begin
      if (statWr)              autoClrQ <= csrWrData[7];
      if (csrWrEn && csrAddr)  maxPktQ  <= LW'(csrWrData);

      if (st.rollback || st.commit) curLen <= '0;
      else if (st.wrByte)           curLen <= curLen + LW'(1);

      if (st.pop)         rdCnt <= '0;
      else if (st.rdByte) rdCnt <= rdCnt + LW'(1);

      // commit with pop happens only with one packet held in two-slot mode
      if (st.commit && st.pop) begin
        lenQ[0] <= curLen;
      end else if (st.commit) begin
        lenQ[pktCnt[0]] <= curLen;
        pktCnt <= pktCnt + 2'd1;
      end else if (st.pop) begin
        lenQ[0] <= lenQ[1];
        pktCnt <= pktCnt - 2'd1;
      end
    end
  end

  assign csrRdData = csrAddr ? 8'(maxPktQ) : {autoClrQ, 6'b0, pktRdy};
endmodule

// File: rtl/usbOutFifo.sv
module usbOutFifo
  import usbOutPkg::*;
#(
  parameter int DEPTH = 64,
  localparam int AW = $clog2(DEPTH),
  localparam int LW = AW + 1
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       ctrlStyle,
  input  logic       rxValid,
  input  logic [7:0] rxData,
  input  logic       rxGood,
  input  logic       rxBad,
  output logic       rxFull,
  input  logic       rdEn,
  output logic [7:0] rdData,
  output logic       pktRdy,
  input  logic       csrWrEn,
  input  logic       csrAddr,
  input  logic [7:0] csrWrData,
  output logic [7:0] csrRdData
);
  fifoStrobe_t   st;
  logic [LW-1:0] popLen;
  logic [LW-1:0] maxPkt;

  outFifoCtrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rstN(rstN), .ctrlStyle(ctrlStyle),
    .rxValid(rxValid), .rxGood(rxGood), .rxBad(rxBad), .rdEn(rdEn),
    .csrWrEn(csrWrEn), .csrAddr(csrAddr), .csrWrData(csrWrData),
    .st(st), .popLen(popLen), .maxPkt(maxPkt), .pktRdy(pktRdy),
    .rxFull(rxFull), .csrRdData(csrRdData)
  );

  outFifoData #(.DEPTH(DEPTH)) u_data (
    .clk(clk), .rstN(rstN), .st(st), .wrData(rxData),
    .popLen(popLen), .rdData(rdData)
  );
endmodule

// File: rtl/usbOutFifoChk.sv
module usbOutFifoChk #(
  parameter int DEPTH = 64,
  localparam int LW = $clog2(DEPTH) + 1
) (
  input logic          clk,
  input logic          rstN,
  input logic          ctrlStyle,
  input logic          rxGood,
  input logic          rxBad,
  input logic          rdEn,
  input logic          csrWrEn,
  input logic          csrAddr,
  input logic [7:0]    csrWrData,
  input logic          pktRdy,
  input logic          rxFull,
  input logic [LW-1:0] maxPkt
);
  p_rdy_cause_r2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pktRdy) |-> $past(rxGood));

  p_full_has_pkt_r3: assert property (@(posedge clk) disable iff (!rstN)
    rxFull |-> pktRdy);

  p_single_full_r3: assert property (@(posedge clk) disable iff (!rstN)
    (pktRdy && (maxPkt > LW'(DEPTH / 2))) |-> rxFull);

  p_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    (pktRdy && !csrWrEn && !rdEn) |=> pktRdy);

  p_ctrl_keep_r7: assert property (@(posedge clk) disable iff (!rstN)
    (pktRdy && ctrlStyle && !(csrWrEn && !csrAddr && (csrWrData[6] || csrWrData[4])))
      |=> pktRdy);

  p_bad_stable_r8: assert property (@(posedge clk) disable iff (!rstN)
    (rxBad && !rxGood && !csrWrEn && !rdEn) |=> $stable(pktRdy));
endmodule

bind usbOutFifo usbOutFifoChk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rstN(rstN), .ctrlStyle(ctrlStyle), .rxGood(rxGood),
  .rxBad(rxBad), .rdEn(rdEn), .csrWrEn(csrWrEn), .csrAddr(csrAddr),
  .csrWrData(csrWrData), .pktRdy(pktRdy), .rxFull(rxFull), .maxPkt(maxPkt)
);

// File: tb/usbOutFifo_tb.sv
module usbOutFifo_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 64;

  logic clk = 1'b0, rstN = 1'b0, ctrlStyle = 1'b0;
  logic rxValid = 1'b0, rxGood = 1'b0, rxBad = 1'b0, rdEn = 1'b0;
  logic csrWrEn = 1'b0, csrAddr = 1'b0;
  logic [7:0] rxData = '0, csrWrData = '0;
  logic rxFull, pktRdy;
  logic [7:0] rdData, csrRdData;

  int checks = 0, fails = 0;
  int mId[2], mLen[2];
  int mCnt = 0, mRd = 0, maxP = DEPTH, nextId = 1;
  bit aClr = 0, cStyle = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  usbOutFifo #(.DEPTH(DEPTH)) u_dut (
    .clk(clk), .rstN(rstN), .ctrlStyle(ctrlStyle), .rxValid(rxValid),
    .rxData(rxData), .rxGood(rxGood), .rxBad(rxBad), .rxFull(rxFull),
    .rdEn(rdEn), .rdData(rdData), .pktRdy(pktRdy), .csrWrEn(csrWrEn),
    .csrAddr(csrAddr), .csrWrData(csrWrData), .csrRdData(csrRdData)
  );

  function automatic logic [7:0] expByte(int id, int i);
    return 8'((id * 37 + i * 11 + 5) & 255);
  endfunction

  function automatic int capOf(int m);
    return (m <= DEPTH / 2) ? 2 : 1;
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic chkFlags(string req);
    chk(req, int'(pktRdy), int'(mCnt != 0));
    chk(req, int'(rxFull), int'(mCnt >= capOf(maxP)));
  endtask

  task automatic mPop();
    if (mCnt > 0) begin
      mId[0] = mId[1]; mLen[0] = mLen[1];
      mCnt--; mRd = 0;
    end
  endtask

  task automatic csrWr(bit a, logic [7:0] d);
    @(negedge clk);
    csrWrEn = 1'b1; csrAddr = a; csrWrData = d;
    @(negedge clk);
    csrWrEn = 1'b0; csrAddr = 1'b0; csrWrData = '0;
  endtask

  task automatic csrChk(string req, bit a, int exp);
    csrAddr = a;
    #1;
    chk(req, int'(csrRdData), exp);
    csrAddr = 1'b0;
  endtask

  task automatic sendPkt(int len, bit bad);
    int id = nextId++;
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      rxValid = 1'b1; rxData = expByte(id, i);
    end
    @(negedge clk);
    rxValid = 1'b0; rxGood = !bad; rxBad = bad;
    @(negedge clk);
    rxGood = 1'b0; rxBad = 1'b0;
    if (!bad && mCnt < capOf(maxP)) begin
      mId[mCnt] = id; mLen[mCnt] = len; mCnt++;
    end
  endtask

  task automatic rdByte();
    bit live = (mCnt > 0) && (mRd < mLen[0]);
    if (live) chk("R1 data", int'(rdData), int'(expByte(mId[0], mRd)));
    rdEn = 1'b1;
    @(negedge clk);
    rdEn = 1'b0;
    if (live) begin
      mRd++;
      if (aClr && !cStyle && mRd == maxP) mPop();
    end
  endtask

  task automatic clearPkt();
    csrWr(1'b0, {aClr, 7'b0});
    if (!cStyle) mPop();
  endtask

  task automatic service();
    csrWr(1'b0, {aClr, 1'b1, 5'b0, 1'b1});
    if (cStyle) mPop();
  endtask

  task automatic flushPkt();
    csrWr(1'b0, {aClr, 2'b0, 1'b1, 3'b0, 1'b1});
    mPop();
  endtask

  task automatic setAuto(bit b);
    csrWr(1'b0, {b, 6'b0, 1'b1});
    aClr = b;
  endtask

  task automatic setMax(int v);
    csrWr(1'b1, 8'(v));
    maxP = v;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog R1 act=0 exp=1");
    $display("test done: total=%0d bad=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] held;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R2 / R10 reset state
    chk("R2 reset pktRdy", int'(pktRdy), 0);
    chk("R2 reset rxFull", int'(rxFull), 0);
    csrChk("R10 status reset", 1'b0, 0);
    csrChk("R10 maxpkt reset", 1'b1, DEPTH);

    // R1/R2 basic packet, R4 manual release
    setMax(32);
    sendPkt(5, 0); chkFlags("R2");
    for (int i = 0; i < 5; i++) rdByte();
    clearPkt(); chkFlags("R4");

    // R3 two-slot mode and full drop; R4 second packet keeps ready
    sendPkt(32, 0); sendPkt(32, 0); chkFlags("R3 two held");
    sendPkt(8, 0); chkFlags("R3 third ignored");
    for (int i = 0; i < 32; i++) rdByte();
    clearPkt(); chk("R4 stays with second", int'(pktRdy), 1);
    for (int i = 0; i < 32; i++) rdByte();
    clearPkt(); chkFlags("R4 empty");

    // R3 one-slot mode
    setMax(48);
    sendPkt(10, 0); chk("R3 single full", int'(rxFull), 1);
    sendPkt(6, 0); chkFlags("R3 single ignored");
    for (int i = 0; i < 10; i++) rdByte();
    clearPkt(); chkFlags("R3");

    // R5 auto-clear
    setMax(32); setAuto(1);
    sendPkt(32, 0); sendPkt(32, 0);
    for (int i = 0; i < 32; i++) rdByte();
    chk("R5 auto keeps second", int'(pktRdy), 1);
    for (int i = 0; i < 32; i++) rdByte();
    chk("R5 auto empty", int'(pktRdy), 0);
    csrChk("R10 status auto", 1'b0, 8'h80);

    // R6 flush drops the older packet only
    setAuto(0);
    sendPkt(4, 0); sendPkt(6, 0);
    flushPkt(); chk("R6 one left", int'(pktRdy), 1);
    for (int i = 0; i < 6; i++) rdByte();
    flushPkt(); chkFlags("R6 empty");

    // R8 rollback
    sendPkt(7, 1); chkFlags("R8 bad ignored");
    sendPkt(3, 0);
    sendPkt(9, 1); chk("R8 ready unchanged", int'(pktRdy), 1);
    sendPkt(2, 0);
    for (int i = 0; i < 3; i++) rdByte();
    clearPkt();
    for (int i = 0; i < 2; i++) rdByte();
    clearPkt(); chkFlags("R8");

    // R9 reads ignored when empty and past packet end
    repeat (3) rdByte();
    sendPkt(4, 0);
    for (int i = 0; i < 4; i++) rdByte();
    held = rdData;
    repeat (2) rdByte();
    chk("R9 past end stable", int'(rdData), int'(held));
    clearPkt(); chkFlags("R9");

    // R7 control-endpoint convention
    @(negedge clk); ctrlStyle = 1'b1; cStyle = 1;
    sendPkt(5, 0);
    clearPkt(); chk("R7 zero write no effect", int'(pktRdy), 1);
    for (int i = 0; i < 5; i++) rdByte();
    service(); chkFlags("R7 serviced");
    @(negedge clk); ctrlStyle = 1'b0; cStyle = 0;
    service(); chkFlags("R7 serviced ignored");

    // constrained random mix
    void'($urandom(32'h5EED_0042));
    for (int it = 0; it < 400; it++) begin
      int op = $urandom_range(0, 7);
      case (op)
        0, 1: sendPkt($urandom_range(0, maxP), 0);
        2: sendPkt($urandom_range(0, maxP), 1);
        3, 4: begin
          int n = $urandom_range(1, 12);
          for (int k = 0; k < n; k++) rdByte();
        end
        5: clearPkt();
        6: if ($urandom_range(0, 1) == 1) flushPkt(); else setAuto(!aClr);
        default: if (mCnt == 0) begin
          int pick = $urandom_range(0, 3);
          setMax(pick == 0 ? 16 : pick == 1 ? 32 : pick == 2 ? 40 : 64);
        end
      endcase
      chkFlags("R3 random");
    end

    $display("test done: total=%0d bad=%0d", checks, fails);
    $finish;
  end
endmodule